// File: doc/BRIEF.md
# Dual-Result Paired-Operation ALU

This unit carries out fused operation pairs: two related operations that read the same two source operands and return two results, one for each of two destination registers. A 4-bit selector picks the pair. Operands and results are XLEN bits wide, with a default of 32. The pairs are:

- add with its carry-out
- subtract with add
- signed or unsigned min with max
- and with bit-clear
- a high product with the low product
- signed or unsigned quotient with remainder

The pipeline presents both sources, the selector and a one-cycle start strobe. Most pairs finish in one cycle. The divide pairs use an iterative restoring divider that does one quotient bit per cycle. While that divider runs the unit reports busy, and it ignores any new start. Completion is marked by a done pulse, and both results are held until the next completion. Selectors that no pair uses are reported as illegal. Register file access and writeback arbitration sit outside this block.

Top module: `pairalu`

## Requirements
- R1: While reset is held, and after it is released with no start, the outputs are as follows: `done`, `illegal` and `busy` are low, and `res_a` and `res_b` are zero.
- R2: Selector 0 returns `res_a` = rs1+rs2 modulo 2^XLEN. `res_b` carries the unsigned carry-out of that addition in bit 0, and all its upper bits are zero.
- R3: Selector 1 returns `res_a` = rs1−rs2 and `res_b` = rs1+rs2, both modulo 2^XLEN.
- R4: Selector 2 returns the signed minimum in `res_a` and the signed maximum in `res_b`. Selector 3 does the same with unsigned comparison.
- R5: Selector 4 returns `res_a` = rs1 AND rs2 and `res_b` = rs1 AND NOT rs2.
- R6: Selectors 5, 6 and 7 return in `res_a` the upper XLEN bits of the 2·XLEN-bit product. Selector 5 treats rs1 as signed and rs2 as unsigned, selector 6 treats both as signed, and selector 7 treats both as unsigned. `res_b` is always the lower XLEN bits of the product.
- R7: Selector 8 (signed) and selector 9 (unsigned) return the quotient in `res_a` and the remainder in `res_b`. The quotient is rounded toward zero, and the remainder takes the sign of rs1.
- R8: A divisor of zero gives a quotient of all ones and a remainder equal to rs1. Signed division of the most negative value by −1 gives a quotient equal to rs1 and a remainder of zero.
- R9: Selectors 10 to 15 complete with `illegal` high in the same cycle as `done`, and both results are zero.
- R10: `done` is high in the first cycle after the accepting clock edge for every selector except 8 and 9. For selectors 8 and 9 it is high XLEN+2 cycles after that edge, counting the cycle right after the edge as cycle 1. `busy` is high from the cycle after a divide is accepted until the cycle before its `done`, and `done` is never high while `busy` is high.
- R11: A start while `busy` is high is ignored. It produces no extra `done`, and it leaves the pending divide results unchanged. The results change only in cycles where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation; accepted when busy is low |
| sel | input | 4 | Pair selector |
| rs1 | input | XLEN | First source operand |
| rs2 | input | XLEN | Second source operand |
| res_a | output | XLEN | First result |
| res_b | output | XLEN | Second result |
| done | output | 1 | Results valid, one cycle per completed operation |
| illegal | output | 1 | Completed operation used a reserved selector |
| busy | output | 1 | Divider occupied; starts are ignored |

## Verification
Random operands across all sixteen selectors check every pair against independently computed reference results. Small operands reach the equal-operand and near-zero cases, and full-range operands reach sign and carry boundaries. Directed vectors cover the following corners:

- carry out of all-ones plus one
- min/max with mixed signs, which separates the signed pair from the unsigned one
- high products of −1 by −1 under all three signedness choices
- divide by zero and the most-negative-by-minus-one case, for both divide pairs

A start pulsed in the middle of a divide shows whether the busy interlock holds: the first result must arrive with the divide latency, and no second completion may follow.

// File: rtl/pairalu_pkg.sv
package pairalu_pkg;

  typedef enum logic [3:0] {
    PSEL_ADDC    = 4'd0,
    PSEL_SUBADD  = 4'd1,
    PSEL_MINMAX  = 4'd2,
    PSEL_MINMAXU = 4'd3,
    PSEL_ANDBIC  = 4'd4,
    PSEL_MULHSU  = 4'd5,
    PSEL_MULH    = 4'd6,
    PSEL_MULHU   = 4'd7,
    PSEL_DIVREM  = 4'd8,
    PSEL_DIVREMU = 4'd9
  } pair_sel_e;

  localparam logic [3:0] PSEL_LAST_USED = 4'd9;

  function automatic logic sel_is_div(input logic [3:0] s);
    return (s == PSEL_DIVREM) || (s == PSEL_DIVREMU);
  endfunction

  function automatic logic sel_is_reserved(input logic [3:0] s);
    return s > PSEL_LAST_USED;
  endfunction

endpackage

// File: rtl/pairalu_rstsync.sv
module pairalu_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pairalu_mul.sv
module pairalu_mul #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            a_signed,
  input  logic            b_signed,
  output logic [XLEN-1:0] hi,
  output logic [XLEN-1:0] lo
);
  localparam int PW = 2 * XLEN;

  logic          a_ext, b_ext;
  logic [PW-1:0] a_wide, b_wide, prod;

  always_comb begin
    a_ext  = a_signed & a[XLEN-1];
    b_ext  = b_signed & b[XLEN-1];
    a_wide = {{XLEN{a_ext}}, a};
    b_wide = {{XLEN{b_ext}}, b};
    prod   = a_wide * b_wide;
  end

  assign hi = prod[PW-1:XLEN];
  assign lo = prod[XLEN-1:0];
endmodule

// File: rtl/pairalu_single.sv
module pairalu_single
  import pairalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      sel,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] ra,
  output logic [XLEN-1:0] rb
);
  logic [XLEN:0]   sum_ext;
  logic [XLEN-1:0] diff;
  logic            lt_s, lt_u;
  logic            m_as, m_bs;
  logic [XLEN-1:0] m_hi, m_lo;

  always_comb begin
    sum_ext = {1'b0, a} + {1'b0, b};
    diff    = a - b;
    lt_s    = $signed(a) < $signed(b);
    lt_u    = a < b;
    m_as    = (sel == PSEL_MULHSU) || (sel == PSEL_MULH);
    m_bs    = (sel == PSEL_MULH);
  end

  pairalu_mul #(.XLEN(XLEN)) u_mul (
    .a        (a),
    .b        (b),
    .a_signed (m_as),
    .b_signed (m_bs),
    .hi       (m_hi),
    .lo       (m_lo)
  );

  always_comb begin
    ra = '0;
    rb = '0;
    case (sel)
      PSEL_ADDC: begin
        ra = sum_ext[XLEN-1:0];
        rb = {{(XLEN-1){1'b0}}, sum_ext[XLEN]};
      end
      PSEL_SUBADD: begin
        ra = diff;
        rb = sum_ext[XLEN-1:0];
      end
      PSEL_MINMAX: begin
        ra = lt_s ? a : b;
        rb = lt_s ? b : a;
      end
      PSEL_MINMAXU: begin
        ra = lt_u ? a : b;
        rb = lt_u ? b : a;
      end
      PSEL_ANDBIC: begin
        ra = a & b;
        rb = a & ~b;
      end
      PSEL_MULHSU, PSEL_MULH, PSEL_MULHU: begin
        ra = m_hi;
        rb = m_lo;
      end
      default: begin
        ra = '0;
        rb = '0;
      end
    endcase
  end
endmodule

// File: rtl/pairalu_div.sv
module pairalu_div #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sgn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            busy,
  output logic            fin,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);
  localparam int CW = $clog2(XLEN + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(XLEN);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic            busy_q, busy_n;
  logic            fin_q, fin_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [XLEN-1:0] rem_q, rem_n;
  logic [XLEN-1:0] quo_q, quo_n;
  logic [XLEN-1:0] dvs_q, dvs_n;
  logic [XLEN-1:0] dnd_q, dnd_n;
  logic            negq_q, negq_n;
  logic            negr_q, negr_n;
  logic            dz_q, dz_n;
  logic            work_en;
  logic [XLEN:0]   trial;
  logic            a_neg, b_neg;

  always_comb begin
    a_neg   = sgn & a[XLEN-1];
    b_neg   = sgn & b[XLEN-1];
    trial   = {rem_q, quo_q[XLEN-1]} - {1'b0, dvs_q};
    work_en = start | busy_q;

    busy_n = busy_q;
    fin_n  = 1'b0;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    dnd_n  = dnd_q;
    negq_n = negq_q;
    negr_n = negr_q;
    dz_n   = dz_q;

    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CNT_INIT;
      rem_n  = '0;
      quo_n  = a_neg ? (~a + 1'b1) : a;
      dvs_n  = b_neg ? (~b + 1'b1) : b;
      dnd_n  = a;
      negq_n = a_neg ^ b_neg;
      negr_n = a_neg;
      dz_n   = (b == '0);
    end else if (busy_q) begin
      if (!trial[XLEN]) begin
        rem_n = trial[XLEN-1:0];
        quo_n = {quo_q[XLEN-2:0], 1'b1};
      end else begin
        rem_n = {rem_q[XLEN-2:0], quo_q[XLEN-1]};
        quo_n = {quo_q[XLEN-2:0], 1'b0};
      end
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_ONE) begin
        busy_n = 1'b0;
        fin_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      fin_q  <= fin_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dnd_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (work_en) begin
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dvs_q  <= dvs_n;
      dnd_q  <= dnd_n;
      negq_q <= negq_n;
      negr_q <= negr_n;
      dz_q   <= dz_n;
    end
  end

  always_comb begin
    if (dz_q) begin
      quo = '1;
      rem = dnd_q;
    end else begin
      quo = negq_q ? (~quo_q + 1'b1) : quo_q;
      rem = negr_q ? (~rem_q + 1'b1) : rem_q;
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
endmodule

// File: rtl/pairalu.sv
module pairalu
  import pairalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      sel,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  output logic [XLEN-1:0] res_a,
  output logic [XLEN-1:0] res_b,
  output logic            done,
  output logic            illegal,
  output logic            busy
);
  logic            srst_n;
  logic            accept, acc_single, acc_div, resv;
  logic [XLEN-1:0] s_ra, s_rb;
  logic            d_busy, d_fin;
  logic [XLEN-1:0] d_quo, d_rem;
  logic            cap_en;
  logic [XLEN-1:0] ra_n, rb_n;
  logic            done_n, ill_n;
  logic [XLEN-1:0] ra_q, rb_q;
  logic            done_q, ill_q;

  pairalu_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign busy = d_busy | d_fin;

  always_comb begin
    accept     = start & ~busy;
    resv       = sel_is_reserved(sel);
    acc_div    = accept & sel_is_div(sel);
    acc_single = accept & ~sel_is_div(sel);
  end

  pairalu_single #(.XLEN(XLEN)) u_single (
    .sel (sel),
    .a   (rs1),
    .b   (rs2),
    .ra  (s_ra),
    .rb  (s_rb)
  );

  pairalu_div #(.XLEN(XLEN)) u_div (
    .clk   (clk),
    .rst_n (srst_n),
    .start (acc_div),
    .sgn   (sel == PSEL_DIVREM),
    .a     (rs1),
    .b     (rs2),
    .busy  (d_busy),
    .fin   (d_fin),
    .quo   (d_quo),
    .rem   (d_rem)
  );

  always_comb begin
    cap_en = acc_single | d_fin;
    done_n = cap_en;
    ill_n  = acc_single & resv;
    if (d_fin) begin
      ra_n = d_quo;
      rb_n = d_rem;
    end else if (resv) begin
      ra_n = '0;
      rb_n = '0;
    end else begin
      ra_n = s_ra;
      rb_n = s_rb;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      ill_q  <= ill_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ra_q <= '0;
      rb_q <= '0;
    end else if (cap_en) begin
      ra_q <= ra_n;
      rb_q <= rb_n;
    end
  end

  assign res_a   = ra_q;
  assign res_b   = rb_q;
  assign done    = done_q;
  assign illegal = ill_q;
endmodule

// File: rtl/pairalu_chk.sv
module pairalu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [3:0]      sel,
  input logic [XLEN-1:0] rs1,
  input logic [XLEN-1:0] rs2,
  input logic [XLEN-1:0] res_a,
  input logic [XLEN-1:0] res_b,
  input logic            done,
  input logic            illegal,
  input logic            busy
);
  logic acc;
  assign acc = start && !busy;

  assert_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == 4'd0) |=>
      (res_b == {{(XLEN-1){1'b0}}, (res_a < $past(rs1))}));

  assert_minmax_signed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == 4'd2) |=> ($signed(res_a) <= $signed(res_b)));

  assert_minmax_unsigned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == 4'd3) |=> (res_a <= res_b));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel > 4'd9) |=> (done && illegal && res_a == '0 && res_b == '0));

  assert_illegal_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  assert_div_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (sel == 4'd8 || sel == 4'd9)) |=> (busy && !done));

  assert_busy_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_results_only_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(res_a) && $stable(res_b)) |-> done);
endmodule

bind pairalu pairalu_chk #(.XLEN(XLEN)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .sel     (sel),
  .rs1     (rs1),
  .rs2     (rs2),
  .res_a   (res_a),
  .res_b   (res_b),
  .done    (done),
  .illegal (illegal),
  .busy    (busy)
);

// File: tb/test_pairalu.sv
module test_pairalu;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] sel;
  word_t      rs1, rs2;
  word_t      res_a, res_b;
  logic       done, illegal, busy;

  int n_vec;
  int n_bad;

  pairalu #(.XLEN(XLEN)) i_pairalu (
    .clk (clk), .rst_n (rst_n), .start (start), .sel (sel),
    .rs1 (rs1), .rs2 (rs2), .res_a (res_a), .res_b (res_b),
    .done (done), .illegal (illegal), .busy (busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [3:0] s, input word_t a, input word_t b,
                       output word_t ea, output word_t eb, output logic eill);
    logic [2*XLEN-1:0] p;
    logic [XLEN:0]     sm;
    eill = 1'b0;
    ea = '0;
    eb = '0;
    sm = {1'b0, a} + {1'b0, b};
    case (s)
      4'd0: begin ea = sm[XLEN-1:0]; eb = word_t'(sm[XLEN]); end
      4'd1: begin ea = a - b; eb = a + b; end
      4'd2: begin
        ea = ($signed(a) < $signed(b)) ? a : b;
        eb = ($signed(a) < $signed(b)) ? b : a;
      end
      4'd3: begin ea = (a < b) ? a : b; eb = (a < b) ? b : a; end
      4'd4: begin ea = a & b; eb = a & ~b; end
      4'd5: begin
        p = {{XLEN{a[XLEN-1]}}, a} * {{XLEN{1'b0}}, b};
        ea = p[2*XLEN-1:XLEN]; eb = p[XLEN-1:0];
      end
      4'd6: begin
        p = {{XLEN{a[XLEN-1]}}, a} * {{XLEN{b[XLEN-1]}}, b};
        ea = p[2*XLEN-1:XLEN]; eb = p[XLEN-1:0];
      end
      4'd7: begin
        p = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
        ea = p[2*XLEN-1:XLEN]; eb = p[XLEN-1:0];
      end
      4'd8: begin
        if (b == '0) begin ea = '1; eb = a; end
        else if (a == {1'b1, {(XLEN-1){1'b0}}} && b == '1) begin ea = a; eb = '0; end
        else begin
          ea = word_t'($signed(a) / $signed(b));
          eb = word_t'($signed(a) % $signed(b));
        end
      end
      4'd9: begin
        if (b == '0) begin ea = '1; eb = a; end
        else begin ea = a / b; eb = a % b; end
      end
      default: eill = 1'b1;
    endcase
  endtask

  task automatic run_op(input logic [3:0] s, input word_t a, input word_t b,
                        input string tag);
    word_t ea, eb;
    logic  eill;
    int    lat;
    int    exp_lat;
    model(s, a, b, ea, eb, eill);
    exp_lat = (s == 4'd8 || s == 4'd9) ? XLEN + 2 : 1;
    @(negedge clk);
    start = 1'b1; sel = s; rs1 = a; rs2 = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R10", {tag, " latency"}, lat, exp_lat);
    check(req_of(s), {tag, " res_a"}, res_a, ea);
    check(req_of(s), {tag, " res_b"}, res_b, eb);
    check("R9", {tag, " illegal"}, illegal, eill);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    word_t mn;
    int    lat;
    n_vec = 0;
    n_bad = 0;
    void'($urandom(32'h1357_9bdf));
    mn = {1'b1, {(XLEN-1){1'b0}}};
    rst_n = 1'b0; start = 1'b0; sel = '0; rs1 = '0; rs2 = '0;
    repeat (4) @(negedge clk);
    check("R1", "done in reset", done, 0);
    check("R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "done after reset", done, 0);
    check("R1", "illegal after reset", illegal, 0);
    check("R1", "busy after reset", busy, 0);
    check("R1", "res_a after reset", res_a, 0);
    check("R1", "res_b after reset", res_b, 0);

    // directed corners
    run_op(4'd0, '1, 32'd1, "R2 carry wrap");
    run_op(4'd0, 32'd5, 32'd6, "R2 no carry");
    run_op(4'd1, 32'd3, 32'd10, "R3 sub/add");
    run_op(4'd2, 32'hFFFF_FFF0, 32'd4, "R4 signed mixed");
    run_op(4'd3, 32'hFFFF_FFF0, 32'd4, "R4 unsigned mixed");
    run_op(4'd4, 32'hF0F0_FF00, 32'hFF00_0F0F, "R5 and/bic");
    run_op(4'd5, '1, '1, "R6 mulhsu -1");
    run_op(4'd6, '1, '1, "R6 mulh -1");
    run_op(4'd7, '1, '1, "R6 mulhu -1");
    run_op(4'd8, 32'hFFFF_FFF9, 32'd2, "R7 signed neg");
    run_op(4'd9, 32'd100, 32'd7, "R7 unsigned");
    run_op(4'd8, 32'h1234, '0, "R8 signed div0");
    run_op(4'd9, 32'h1234, '0, "R8 unsigned div0");
    run_op(4'd8, mn, '1, "R8 overflow");
    run_op(4'd12, 32'd1, 32'd2, "R9 reserved 12");
    run_op(4'd15, '1, '1, "R9 reserved 15");

    // R11: start pulsed during a divide is ignored
    @(negedge clk);
    start = 1'b1; sel = 4'd8; rs1 = 32'd100; rs2 = 32'd7;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    start = 1'b1; sel = 4'd0; rs1 = 32'd1; rs2 = 32'd2;
    @(negedge clk);
    start = 1'b0;
    lat++;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R11", "latency with ignored start", lat, XLEN + 2);
    check("R11", "quotient kept", res_a, 14);
    check("R11", "remainder kept", res_b, 2);
    @(negedge clk);
    check("R11", "no extra done", done, 0);
    check("R11", "res_a unchanged", res_a, 14);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] s;
      word_t a, b;
      s = 4'($urandom % 16);
      a = $urandom;
      b = $urandom;
      if (($urandom % 4) == 0) begin
        a = word_t'($urandom % 16);
        b = word_t'($urandom % 16);
      end
      run_op(s, a, b, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule